// File: doc/BRIEF.md
# Three-Channel Skew Delay-Code SPI Register Slave

This block is the digital control port for a three-channel video skew compensator. A host writes a 6-bit delay code for each of the red, green and blue paths over a 4-wire SPI link. The block stores the three codes and drives them in parallel to the logic that selects the delay taps. The host can also read back any stored code over the same link.

The SPI pins are sampled by a system clock that runs at least four times faster than SCK. SCK, CS and SDI each pass through a two-flop synchronizer, and SCK edges are found in the system clock domain. A frame is always two bytes long. The first byte is a command byte: it carries a read/write flag and a colour select. The second byte carries the code to store, or it carries the stored code back on SDO.

A small state machine tracks the frame. Its states are `ST_IDLE` (CS released), `ST_CMD` (shifting in the command byte), `ST_DATA` (the data byte) and `ST_DONE` (all 16 bits seen, waiting for CS release). Its transitions are:

- `ST_IDLE` → `ST_CMD` when the synchronized CS goes low.
- `ST_CMD` → `ST_DATA` on the 8th SCK rise.
- `ST_DATA` → `ST_DONE` on the 16th SCK rise. A write is committed on this edge.
- Any state → `ST_IDLE` when CS goes high. The 16th edge still commits if CS rises in the same cycle, and in that case the machine goes straight from `ST_DATA` to `ST_IDLE`.

Top module: `skew_code_spi_slave`

## Requirements
- R1: After reset all three delay codes are 0 and SDO is 0.
- R2: A frame is framed by active-low CS and carries 16 bits, MSB first. SDI is captured on each rising SCK edge. In the command byte, bit 7 is the direction flag (0 = write, 1 = read), bits 6..2 are zero, and bits 1..0 select the register: 00 red, 01 green, 10 blue.
- R3: On a write, bits 5..0 of the second byte become the selected code, and bits 7..6 of that byte have no effect.
- R4: A write takes effect only when the 16th bit is captured. A frame ended by CS rising before its 16th SCK rise leaves all codes unchanged.
- R5: A write with select 11 changes no code.
- R6: On a read, SDO is updated after falling SCK edges. At rising edges 1..10 it reads 0. At rising edges 11..16 it carries the selected code, MSB first. A read changes no code.
- R7: A read with select 11 returns 0 in all bits.
- R8: SDO is 0 whenever CS is high.
- R9: SCK rises after the 16th within the same frame are ignored. The code written stays the one from bits 5..0 of the second byte.
- R10: If CS rises in the same system cycle in which the 16th SCK rise is seen, the write is still committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock from the host, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sdi | input | 1 | SPI data from the host |
| spi_sdo | output | 1 | SPI data to the host |
| delay_red | output | CODE_W | Stored red delay code |
| delay_green | output | CODE_W | Stored green delay code |
| delay_blue | output | CODE_W | Stored blue delay code |

## Verification
Two events can fall in the same system cycle: the write commit on the 16th SCK rise and the release of CS that closes the frame. The bench provokes this by driving the last SCK rise and the CS release at the same instant. Both then pass through synchronizers of equal depth and reach the state machine together. The test passes if the blue code takes the new value (R10). The bench also runs the neighbouring cases: a release one bit early, which must discard the write (R4), and extra SCK pulses after the 16th bit, which must be ignored (R9).

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int NUM_CH = 3;
    localparam int SEL_W  = 2;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_DONE
    } frame_state_t;
endpackage

// File: rtl/dcr_sync.sv
module dcr_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dcr_code_bank.sv
module dcr_code_bank
    import dcr_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [CODE_W-1:0]            wr_code,
    input  logic [SEL_W-1:0]             rd_sel,
    output logic [CODE_W-1:0]            rd_code,
    output logic [NUM_CH-1:0][CODE_W-1:0] codes_o
);
    logic [NUM_CH-1:0][CODE_W-1:0] code_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                       code_q[ch] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(ch)))         code_q[ch] <= wr_code;
        end
    end

    always_comb begin
        rd_code = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (rd_sel == SEL_W'(ch)) rd_code = code_q[ch];
        end
    end

    assign codes_o = code_q;

    // R5
    unused_sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11) |=> $stable(code_q));
endmodule

// File: rtl/dcr_frame_fsm.sv
module dcr_frame_fsm
    import dcr_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              sdi_s,
    input  logic [CODE_W-1:0] rd_code,
    output logic [SEL_W-1:0]  rd_sel,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [CODE_W-1:0] wr_code,
    output logic              sdo_o
);
    localparam int FRAME_BITS = 2 * BYTE_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] TX_LOAD  = CNT_W'(BYTE_W);

    frame_state_t           state_q, state_d;
    logic                   sck_d;
    logic                   sck_rise, sck_fall;
    logic [CNT_W-1:0]       cnt_q;
    logic [BYTE_W-2:0]      shreg_q;
    logic                   rw_q;
    logic [SEL_W-1:0]       sel_q;
    logic [BYTE_W-1:0]      tx_q;
    logic                   sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end
    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!cs_n_s) state_d = ST_CMD;
            ST_CMD: begin
                if (cs_n_s)                             state_d = ST_IDLE;
                else if (sck_rise && cnt_q == LAST_CMD) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (sck_rise && cnt_q == LAST_BIT) state_d = cs_n_s ? ST_IDLE : ST_DONE;
                else if (cs_n_s)                   state_d = ST_IDLE;
            end
            ST_DONE: if (cs_n_s) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_en   = (state_q == ST_DATA) && sck_rise && (cnt_q == LAST_BIT) && !rw_q;
        wr_sel  = sel_q;
        wr_code = {shreg_q[CODE_W-2:0], sdi_s};
        rd_sel  = sel_q;
        sdo_o   = sdo_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            rw_q    <= 1'b0;
            sel_q   <= '0;
            tx_q    <= '0;
            sdo_q   <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            tx_q    <= '0;
            sdo_q   <= 1'b0;
        end else begin
            if (sck_rise && state_q != ST_DONE) begin
                shreg_q <= {shreg_q[BYTE_W-3:0], sdi_s};
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == LAST_CMD) begin
                    rw_q  <= shreg_q[BYTE_W-2];
                    sel_q <= {shreg_q[0], sdi_s};
                end
            end
            if (sck_fall && state_q == ST_DATA) begin
                if (cnt_q == TX_LOAD)
                    tx_q <= rw_q ? {{(BYTE_W-CODE_W){1'b0}}, rd_code} : '0;
                else
                    tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
            sdo_q <= cs_n_s ? 1'b0 : tx_q[BYTE_W-1];
        end
    end

    // R2
    bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FRAME_BITS));
    // R9
    done_full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (cnt_q == CNT_W'(FRAME_BITS)));
    // R4
    release_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_s) |=> (state_q == ST_IDLE));
    // R8
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !sdo_q);
endmodule

// File: rtl/skew_code_spi_slave.sv
module skew_code_spi_slave
    import dcr_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic [CODE_W-1:0] delay_red,
    output logic [CODE_W-1:0] delay_green,
    output logic [CODE_W-1:0] delay_blue
);
    logic [2:0]                    pins_s;
    logic                          wr_en;
    logic [SEL_W-1:0]              wr_sel, rd_sel;
    logic [CODE_W-1:0]             wr_code, rd_code;
    logic [NUM_CH-1:0][CODE_W-1:0] codes;

    dcr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_sck, spi_cs_n, spi_sdi}),
        .q_o   (pins_s)
    );

    dcr_frame_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (pins_s[2]),
        .cs_n_s  (pins_s[1]),
        .sdi_s   (pins_s[0]),
        .rd_code (rd_code),
        .rd_sel  (rd_sel),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_code (wr_code),
        .sdo_o   (spi_sdo)
    );

    dcr_code_bank #(.CODE_W(CODE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_code (wr_code),
        .rd_sel  (rd_sel),
        .rd_code (rd_code),
        .codes_o (codes)
    );

    assign delay_red   = codes[0];
    assign delay_green = codes[1];
    assign delay_blue  = codes[2];
endmodule

// File: tb/skew_code_spi_slave_tb.sv
`timescale 1ns/1ps
module skew_code_spi_slave_tb;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic sdo;
    logic [5:0] d_r, d_g, d_b;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [5:0] exp_c [3];

    always #2.5 clk = ~clk;

    skew_code_spi_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(sdi),
        .spi_sdo(sdo), .delay_red(d_r), .delay_green(d_g), .delay_blue(d_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_codes(input string req);
        chk({req, " red"},   d_r, exp_c[0]);
        chk({req, " green"}, d_g, exp_c[1]);
        chk({req, " blue"},  d_b, exp_c[2]);
    endtask

    task automatic frame(input logic [31:0] word, input int nbits, input bit joint,
                         output logic [31:0] rx);
        rx = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = word[nbits-1-i];
            repeat (HALF) @(negedge clk);
            rx[nbits-1-i] = sdo;
            sck = 1'b1;
            if (joint && i == nbits - 1) cs_n = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic wr(input int sel, input int code, input int top2);
        logic [31:0] rx;
        frame({16'h0, 6'b0, sel[1:0], top2[1:0], code[5:0]}, 16, 1'b0, rx);
    endtask

    initial begin
        logic [31:0] rx;
        int c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        exp_c[0] = 0; exp_c[1] = 0; exp_c[2] = 0;
        chk_codes("R1 reset");
        chk("R1 sdo reset", sdo, 0);

        for (int k = 0; k < 64; k++) begin
            exp_c[0] = 6'(k);
            exp_c[1] = 6'(63 - k);
            exp_c[2] = 6'((k * 5 + 7) % 64);
            // R2 and R3: each colour with varying don't-care top bits
            for (int s = 0; s < 3; s++) wr(s, exp_c[s], (k + s) % 4);
            chk_codes("R3 write sweep");
            c = k % 3;
            frame({16'h0, 8'h80 | 8'(c), 8'h00}, 16, 1'b0, rx);
            chk("R6 read data", rx[15:0], {10'b0, exp_c[c]});
            chk_codes("R6 read leaves codes");
            chk("R8 sdo idle", sdo, 0);
        end

        wr(3, 21, 0);
        chk_codes("R5 select 11 write");
        frame({16'h0, 16'h8300}, 16, 1'b0, rx);
        chk("R7 select 11 read", rx[15:0], 0);

        frame({16'h0, 16'h0015}, 12, 1'b0, rx);
        chk_codes("R4 cut at 12 bits");
        frame({16'h0, 16'h002A}, 15, 1'b0, rx);
        chk_codes("R4 cut at 15 bits");

        frame({12'h0, 16'h012A, 4'hF}, 20, 1'b0, rx);
        exp_c[1] = 6'd42;
        chk_codes("R9 extra clocks");

        frame({16'h0, 16'h0211}, 16, 1'b1, rx);
        exp_c[2] = 6'd17;
        chk_codes("R10 joint release");
        chk("R8 sdo after joint", sdo, 0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule